// File: doc/BRIEF.md
# Lane Power-State and Loopback Controller

This block is the control core of a single-lane serial PHY. It turns a 2-bit power request from the link layer into one of three power states: full-on, a fast-recovery standby and a deeper low-power state. It keeps the transmitter in electrical idle whenever the lane is not fully on. One request pin does two jobs, depending on the current state. In the low-power state it starts a receiver-detection run, which waits a fixed number of cycles for an analog stub and then samples its verdict. In the full-on state it switches the transmitter from link-layer symbols to the received symbols. That switch, and the switch back, happens only on a symbol boundary.

A one-cycle status strobe tells the link layer that a power change has taken effect or that a detection run has finished. The receive path always passes through with one register of latency, including while the lane is looped back. The transmit data and the electrical-idle flag pass through the same single register. A symbol presented in the cycle before the idle request therefore leaves the lane ahead of idle. This is how the link layer places its idle ordered set in front of electrical idle.

Top module: `lane_pm_ctrl`

## Requirements
- R1: `pwrState` reports the state selected by `pwrReq`: 2'b00 is full-on, 2'b01 is standby and 2'b10 is low-power. The new state shows after the clock edge that samples the request, unless a detection run is in progress.
- R2: The unused request code 2'b11 selects low-power (`pwrState` = 2'b10).
- R3: `phyStatus` is high for exactly the one cycle that follows each edge at which `pwrState` changes.
- R4: While `rstN` is low, `phyStatus` is 1, `pwrState` is low-power and `txElecIdle` is 1. With `pwrReq` = 2'b10, `phyStatus` is 0 after the first edge following reset release.
- R5: `txElecIdle` is 1 in standby and in low-power. In full-on it follows `txIdleReq` one cycle later, which is the same latency as `txData`.
- R6: In low-power, a rising edge on `detLpReq` starts a detection run. `detActive` stays high for DET_CYCLES cycles. In the cycle after the run ends, `phyStatus` is 1 and `rxStatus` is 3'b011 if `detResult` was high at the final edge, and 3'b000 if it was low.
- R7: Power requests made during a detection run take effect at the edge after the run completes, and each gives its own `phyStatus` pulse.
- R8: In standby, `detLpReq` has no effect: `detActive`, `loopActive` and `phyStatus` stay 0.
- R9: In full-on, loopback starts only at an edge where `symStrobe` is 1 and `detLpReq` is 1. From that edge on, `txData`/`txK` carry the previous cycle's `rxInData`/`rxInK`.
- R10: With `detLpReq` low, loopback ends at the next edge where `symStrobe` is 1. After that, `txData` carries `linkTxData` again with one cycle of latency.
- R11: `rxData`/`rxK` always equal the previous cycle's `rxInData`/`rxInK`, whether or not the lane is looped back.
- R12: Leaving full-on clears `loopActive` at the same edge, whatever the strobe is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrReq | input | 2 | Requested power state code |
| txIdleReq | input | 1 | Link layer asks for transmit electrical idle |
| detLpReq | input | 1 | Detection request in low-power, loopback request in full-on |
| symStrobe | input | 1 | Marks a symbol boundary |
| detResult | input | 1 | Receiver-present verdict from the analog stub |
| linkTxData | input | DATA_W | Transmit symbol from the link layer |
| linkTxK | input | 1 | Control-symbol flag for linkTxData |
| rxInData | input | DATA_W | Received symbol from the decoder |
| rxInK | input | 1 | Control-symbol flag for rxInData |
| txData | output | DATA_W | Symbol sent to the encoder |
| txK | output | 1 | Control-symbol flag for txData |
| txElecIdle | output | 1 | Transmitter electrical idle |
| rxData | output | DATA_W | Received symbol to the link layer |
| rxK | output | 1 | Control-symbol flag for rxData |
| phyStatus | output | 1 | Completion strobe |
| rxStatus | output | 3 | Detection verdict, valid with phyStatus |
| detActive | output | 1 | Detection run in progress, enables the analog stub |
| loopActive | output | 1 | Transmitter is sending received symbols |
| pwrState | output | 2 | Current power state |

## Verification
A wrong state register shows on `pwrState` and `txElecIdle` one cycle after the faulty edge. It also shows as a missing or extra `phyStatus` pulse in that same cycle. A loopback flag that switches off a symbol boundary puts a received symbol, or a link symbol, on `txData` one cycle early or late. The bench sees this because it drives different values on the two sources in every cycle. A detection counter that is off by one moves the status pulse by one cycle, and the bench checks the exact cycle of the run's end.

// File: rtl/lane_pm_pkg.sv
package lane_pm_pkg;

  typedef enum logic [1:0] {
    PS_ON      = 2'b00,
    PS_STANDBY = 2'b01,
    PS_LOW     = 2'b10
  } pwrState_e;

  // strobes from control to datapath, all next-cycle values
  typedef struct packed {
    logic       selLoop;
    logic       elecIdle;
    logic       statusPulse;
    logic [2:0] rxStat;
  } pathCtl_t;

  localparam logic [2:0] RXST_NONE  = 3'b000;
  localparam logic [2:0] RXST_FOUND = 3'b011;

  function automatic pwrState_e decodeReq(input logic [1:0] code);
    case (code)
      2'b00:   return PS_ON;
      2'b01:   return PS_STANDBY;
      default: return PS_LOW;   // 2'b10 and the unused 2'b11
    endcase
  endfunction

endpackage

// File: rtl/lane_pm_fsm.sv
module lane_pm_fsm
  import lane_pm_pkg::*;
#(
  parameter int unsigned DET_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] pwrReq,
  input  logic      txIdleReq,
  input  logic      detLpReq,
  input  logic      symStrobe,
  input  logic      detResult,
  output pathCtl_t  ctl,
  output pwrState_e curState,
  output logic      detBusy,
  output logic      loopOn
);

  localparam int unsigned CNT_W = (DET_CYCLES > 1) ? $clog2(DET_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DET_CYCLES - 1);

  logic [CNT_W-1:0] detCnt, nxtCnt;
  logic             reqQ;
  logic             nxtBusy, nxtLoop, pulse, reqRise;
  logic [2:0]       stat;
  pwrState_e        target, nxtState;

  always_comb begin
    target   = decodeReq(pwrReq);
    reqRise  = detLpReq & ~reqQ;
    nxtState = curState;
    nxtBusy  = detBusy;
    nxtCnt   = detCnt;
    pulse    = 1'b0;
    stat     = RXST_NONE;
    if (detBusy) begin
      if (detCnt == '0) begin
        nxtBusy = 1'b0;
        pulse   = 1'b1;
        stat    = detResult ? RXST_FOUND : RXST_NONE;
      end else begin
        nxtCnt = detCnt - 1'b1;
      end
    end else if (target != curState) begin
      nxtState = target;
      pulse    = 1'b1;
    end else if (curState == PS_LOW && reqRise) begin
      nxtBusy = 1'b1;
      nxtCnt  = CNT_LOAD;
    end

    if (nxtState != PS_ON)  nxtLoop = 1'b0;
    else if (symStrobe)     nxtLoop = detLpReq;
    else                    nxtLoop = loopOn;

    ctl.selLoop     = nxtLoop;
    ctl.elecIdle    = (nxtState != PS_ON) || txIdleReq;
    ctl.statusPulse = pulse;
    ctl.rxStat      = stat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= PS_LOW;
      detBusy  <= 1'b0;
      detCnt   <= '0;
      loopOn   <= 1'b0;
      reqQ     <= 1'b0;
    end else begin
      curState <= nxtState;
      detBusy  <= nxtBusy;
      detCnt   <= nxtCnt;
      loopOn   <= nxtLoop;
      reqQ     <= detLpReq;
    end
  end

endmodule

// File: rtl/lane_pm_path.sv
module lane_pm_path
  import lane_pm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [DATA_W-1:0] linkTxData,
  input  logic              linkTxK,
  input  logic [DATA_W-1:0] rxInData,
  input  logic              rxInK,
  output logic [DATA_W-1:0] txData,
  output logic              txK,
  output logic              txElecIdle,
  output logic [DATA_W-1:0] rxData,
  output logic              rxK,
  output logic              phyStatus,
  output logic [2:0]        rxStatus
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData     <= '0;
      txK        <= 1'b0;
      txElecIdle <= 1'b1;
      rxData     <= '0;
      rxK        <= 1'b0;
      phyStatus  <= 1'b1;
      rxStatus   <= RXST_NONE;
    end else begin
      txData     <= ctl.selLoop ? rxInData : linkTxData;
      txK        <= ctl.selLoop ? rxInK    : linkTxK;
      txElecIdle <= ctl.elecIdle;
      rxData     <= rxInData;
      rxK        <= rxInK;
      phyStatus  <= ctl.statusPulse;
      rxStatus   <= ctl.rxStat;
    end
  end

endmodule

// File: rtl/lane_pm_ctrl.sv
module lane_pm_ctrl
  import lane_pm_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DET_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pwrReq,
  input  logic              txIdleReq,
  input  logic              detLpReq,
  input  logic              symStrobe,
  input  logic              detResult,
  input  logic [DATA_W-1:0] linkTxData,
  input  logic              linkTxK,
  input  logic [DATA_W-1:0] rxInData,
  input  logic              rxInK,
  output logic [DATA_W-1:0] txData,
  output logic              txK,
  output logic              txElecIdle,
  output logic [DATA_W-1:0] rxData,
  output logic              rxK,
  output logic              phyStatus,
  output logic [2:0]        rxStatus,
  output logic              detActive,
  output logic              loopActive,
  output logic [1:0]        pwrState
);

  pathCtl_t  ctl;
  pwrState_e curState;

  lane_pm_fsm #(.DET_CYCLES(DET_CYCLES)) u_fsm (
    .clk(clk), .rstN(rstN), .pwrReq(pwrReq), .txIdleReq(txIdleReq),
    .detLpReq(detLpReq), .symStrobe(symStrobe), .detResult(detResult),
    .ctl(ctl), .curState(curState), .detBusy(detActive), .loopOn(loopActive)
  );

  lane_pm_path #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .linkTxData(linkTxData), .linkTxK(linkTxK),
    .rxInData(rxInData), .rxInK(rxInK),
    .txData(txData), .txK(txK), .txElecIdle(txElecIdle),
    .rxData(rxData), .rxK(rxK), .phyStatus(phyStatus), .rxStatus(rxStatus)
  );

  assign pwrState = curState;

endmodule

// File: rtl/lane_pm_chk.sv
module lane_pm_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] pwrReq,
  input logic       symStrobe,
  input logic [1:0] pwrState,
  input logic       txElecIdle,
  input logic       loopActive,
  input logic       detActive,
  input logic       phyStatus,
  input logic [2:0] rxStatus
);

  a_r1_follow_code: assert property (@(posedge clk) disable iff (!rstN)
    (!detActive && pwrReq != 2'b11) |=> (pwrState == $past(pwrReq)));

  a_r2_unused_code_low: assert property (@(posedge clk) disable iff (!rstN)
    (!detActive && pwrReq == 2'b11) |=> (pwrState == 2'b10));

  a_r3_change_pulses: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != $past(pwrState)) |-> phyStatus);

  a_r5_idle_when_not_on: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 2'b00) |-> txElecIdle);

  a_r6_detect_in_low: assert property (@(posedge clk) disable iff (!rstN)
    detActive |-> (pwrState == 2'b10));

  a_r6_verdict_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (rxStatus != 3'b000) |-> (phyStatus && rxStatus == 3'b011));

  a_r7_hold_during_detect: assert property (@(posedge clk) disable iff (!rstN)
    detActive |=> $stable(pwrState));

  a_r9_enter_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopActive) |-> $past(symStrobe));

  a_r12_loop_only_on: assert property (@(posedge clk) disable iff (!rstN)
    loopActive |-> (pwrState == 2'b00));

endmodule

bind lane_pm_ctrl lane_pm_chk u_chk (
  .clk(clk), .rstN(rstN), .pwrReq(pwrReq), .symStrobe(symStrobe),
  .pwrState(pwrState), .txElecIdle(txElecIdle), .loopActive(loopActive),
  .detActive(detActive), .phyStatus(phyStatus), .rxStatus(rxStatus)
);

// File: tb/tb_lane_pm_ctrl.sv
module tb_lane_pm_ctrl;

  localparam int DW  = 8;
  localparam int DET = 4;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic [1:0] pwrReq = 2'b10;
  logic txIdleReq = 1'b0, detLpReq = 1'b0, symStrobe = 1'b0, detResult = 1'b0;
  logic [DW-1:0] linkTxData = '0, rxInData = '0;
  logic linkTxK = 1'b0, rxInK = 1'b0;
  logic [DW-1:0] txData, rxData;
  logic txK, txElecIdle, rxK, phyStatus, detActive, loopActive;
  logic [2:0] rxStatus;
  logic [1:0] pwrState;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  lane_pm_ctrl #(.DATA_W(DW), .DET_CYCLES(DET)) dut (
    .clk(clk), .rstN(rstN), .pwrReq(pwrReq), .txIdleReq(txIdleReq),
    .detLpReq(detLpReq), .symStrobe(symStrobe), .detResult(detResult),
    .linkTxData(linkTxData), .linkTxK(linkTxK), .rxInData(rxInData), .rxInK(rxInK),
    .txData(txData), .txK(txK), .txElecIdle(txElecIdle), .rxData(rxData), .rxK(rxK),
    .phyStatus(phyStatus), .rxStatus(rxStatus), .detActive(detActive),
    .loopActive(loopActive), .pwrState(pwrState)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    nTests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic expLoop;
    logic [DW-1:0] prevRx;
    // R4: reset values
    #1 rstN = 1'b0;
    tick(); tick();
    check("R4", "phyStatus in reset", phyStatus, 1);
    check("R4", "pwrState in reset", pwrState, 2'b10);
    check("R4", "txElecIdle in reset", txElecIdle, 1);
    rstN = 1'b1;
    tick();
    check("R4", "phyStatus after reset", phyStatus, 0);
    check("R4", "pwrState after reset", pwrState, 2'b10);

    // R1 R2 R3 R5: sweep every code from every legal state
    for (int from = 0; from < 3; from++) begin
      for (int to = 0; to < 4; to++) begin
        logic [1:0] expS;
        pwrReq = 2'(from);
        tick(); tick();
        check("R1", "settle state", pwrState, 32'(from));
        pwrReq = 2'(to);
        expS = (to == 3) ? 2'b10 : 2'(to);
        tick();
        check(to == 3 ? "R2" : "R1", "new state", pwrState, expS);
        check("R3", "pulse on change", phyStatus, (expS != 2'(from)) ? 1 : 0);
        check("R5", "idle by state", txElecIdle, (expS != 2'b00) ? 1 : 0);
        tick();
        check("R3", "pulse one cycle", phyStatus, 0);
      end
    end

    // R5 R11: full-on data path sweep with idle request
    pwrReq = 2'b00;
    tick(); tick();
    for (int i = 0; i < 256; i++) begin
      linkTxData = 8'(i);
      linkTxK    = i[0];
      rxInData   = 8'(255 - i);
      rxInK      = i[1];
      txIdleReq  = (i % 16) >= 12;
      tick();
      check("R5", "tx data", txData, 32'(i));
      check("R5", "tx idle follows request", txElecIdle, ((i % 16) >= 12) ? 1 : 0);
      check("R11", "rx passthrough", {rxK, rxData}, {i[1], 8'(255 - i)});
    end
    txIdleReq = 1'b0;

    // R9 R10 R11: loopback entry/exit only at symbol boundaries
    expLoop = 1'b0;
    for (int i = 0; i < 60; i++) begin
      detLpReq   = ((i / 7) % 2) == 1;
      symStrobe  = (i % 3) == 2;
      linkTxData = 8'(i * 3);
      rxInData   = 8'(i * 5 + 1);
      prevRx     = rxInData;
      if (symStrobe) expLoop = detLpReq;
      tick();
      check(expLoop ? "R9" : "R10", "loopActive", loopActive, expLoop);
      check(expLoop ? "R9" : "R10", "tx source", txData, expLoop ? prevRx : 8'(i * 3));
      check("R11", "rx during loop", rxData, prevRx);
    end

    // R12: enter loop, then leave full-on without a strobe
    detLpReq = 1'b1; symStrobe = 1'b1;
    tick();
    check("R9", "loop entered", loopActive, 1);
    symStrobe = 1'b0; pwrReq = 2'b01;
    tick();
    check("R12", "loop cleared on exit", loopActive, 0);
    check("R12", "standby state", pwrState, 2'b01);

    // R8: request in standby is ignored
    detLpReq = 1'b0;
    tick(); tick();
    detLpReq = 1'b1;
    for (int i = 0; i < DET + 2; i++) begin
      symStrobe = i[0];
      tick();
      check("R8", "no detect in standby", detActive, 0);
      check("R8", "no loop in standby", loopActive, 0);
      check("R8", "no status in standby", phyStatus, 0);
    end
    detLpReq = 1'b0; symStrobe = 1'b0;

    // R6: detection in low-power, both verdicts
    pwrReq = 2'b10;
    tick(); tick();
    for (int v = 0; v < 2; v++) begin
      detLpReq = 1'b1;
      detResult = 1'b0;
      tick();
      check("R6", "run starts", detActive, 1);
      for (int c = 1; c < DET; c++) begin
        if (c == DET - 1) detResult = v[0];
        tick();
        check("R6", "run busy", detActive, 1);
        check("R6", "no early status", phyStatus, 0);
      end
      tick();
      check("R6", "run ends", detActive, 0);
      check("R6", "status pulse", phyStatus, 1);
      check("R6", "verdict", rxStatus, v[0] ? 3'b011 : 3'b000);
      detLpReq = 1'b0;
      tick();
      check("R6", "status drops", phyStatus, 0);
      check("R6", "verdict clears", rxStatus, 0);
    end

    // R7: power request during detection waits for completion
    detLpReq = 1'b1; detResult = 1'b1;
    tick();
    pwrReq = 2'b00;
    for (int c = 1; c < DET; c++) begin
      tick();
      check("R7", "state held", pwrState, 2'b10);
    end
    tick();
    check("R7", "detect done first", rxStatus, 3'b011);
    check("R7", "still low-power", pwrState, 2'b10);
    tick();
    check("R7", "deferred change", pwrState, 2'b00);
    check("R7", "second pulse", phyStatus, 1);
    check("R7", "no verdict on change", rxStatus, 0);
    detLpReq = 1'b0;
    tick();

    finishRun();
  end

endmodule